// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into an absolute address by walking a hierarchy of translation tables held in memory. A two-bit type field in the address-space control word picks the first table: region-first, region-second, region-third or segment. The walk then reads one 8-byte entry per level through a single-outstanding read port and descends until it reaches a page entry. It stops early when a region-third or segment entry describes a large frame and the matching large-frame enable is on.

A request is taken when `req_valid` is high and `req_busy` is low. Each accepted request yields exactly one `res_valid` pulse. A zero `res_code` means `res_addr` holds the translated address. Any other code names the exception that ended the walk, and `res_addr` is then zero. Setting the real-space bit in the control word skips translation entirely. Prefix relocation is the identity mapping here.

Top module: `dat_walker`

## Requirements
- R1: The control word's field [3:2] selects the first level (0 segment, 1 region-third, 2 region-second, 3 region-first), and its field [63:12] times 4096 is that table's origin. The address indexes are region-first [63:53], region-second [52:42], region-third [41:31], segment [30:20], page [19:12] and byte [11:0]. A region or region-third/segment-level entry is read at origin + index*8, where a region entry's origin is its field [63:12] times 4096. The page entry is read at segment-entry field [63:11] times 2048 + page index*8. A completed walk returns page-entry field [63:12] followed by the byte index, with code 0. Every read address is 8-byte aligned.
- R2: When control-word bit 5 is set, the result is the virtual address unchanged, with code 0, and no read is issued.
- R3: If any index above the starting level is nonzero, the walk ends with code 0x38 and no read is issued.
- R4: If the top two bits of the starting index exceed control-word field [1:0], no read is issued. The code is that level's translation code: region-first 0x39, region-second 0x3A, region-third 0x3B, segment 0x10.
- R5: A region or segment entry whose bit 5 is set ends the walk with its own level's translation code. An entry whose field [3:2] does not equal the level number (region-first 3 down to segment 0) ends it with 0x12.
- R6: In a region entry, if the top two bits of the next index fall below field [7:6] or above field [1:0], the walk ends with the next level's translation code.
- R7: A region-third entry with bit 10 set ends the walk when both enables are on. It returns entry [63:31] followed by virtual address [30:0]. With the second enable off, bit 10 is ignored and the entry points to a segment table.
- R8: A segment entry with bit 10 set ends the walk when the first enable is on. It returns entry [63:20] followed by virtual address [19:0]. A segment entry with bit 4 set while control-word bit 8 is set ends the walk with 0x12.
- R9: In a page entry, bit 10 set gives 0x11 and bit 11 set gives 0x12. Bit 8 set while the first enable is off also gives 0x12.
- R10: Bit 9 of the entries is ORed along the walk. Region-level bits count only when the first enable is on. A write whose accumulated protection is set ends with 0x04, while a read with the same tables succeeds.
- R11: A memory response with the error flag set ends the walk at once with code 0xF0.
- R12: `req_busy` is high from the cycle after acceptance until the result. Requests offered while busy are ignored. Each accepted request yields exactly one `res_valid` pulse, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_busy | output | 1 | Walk in progress; requests ignored |
| req_vaddr | input | 64 | Virtual address to translate |
| req_ctl | input | 64 | Address-space control word |
| req_large_en1 | input | 1 | First large-frame enable (segment frames, region protection) |
| req_large_en2 | input | 1 | Second large-frame enable (region-third frames) |
| req_write | input | 1 | Request is a store |
| mem_rd_valid | output | 1 | One-cycle read request for a table entry |
| mem_rd_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Entry returned by memory |
| mem_rsp_err | input | 1 | Read failed |
| res_valid | output | 1 | One-cycle result pulse |
| res_addr | output | 64 | Translated address, zero on exception |
| res_code | output | 8 | Exception code, zero on success |

## Verification
A wrong level register or pointer shows up on the read port at the very next read. The entry address of that level no longer matches origin plus index times eight, so the bench sees a missing or zero entry and reports a wrong code or address on the pulse that ends that walk. A stale protection accumulator only reveals itself at the final level, and only on writes. For that reason each protection case is run as a read and as a write over the same tables. Faults raised before any read are checked together with the count of reads the walk issued. This catches a start check that leaks a memory access before the fault is reported.

// File: rtl/dat_walk_pkg.sv
package dat_walk_pkg;

  typedef enum logic [2:0] {
    LV_SEG  = 3'd0,
    LV_R3   = 3'd1,
    LV_R2   = 3'd2,
    LV_R1   = 3'd3,
    LV_PAGE = 3'd4
  } lvl_t;

  localparam int VA_W    = 64;
  localparam int IDX_W   = 11;
  localparam int PX_W    = 8;
  localparam int CODE_W  = 8;
  localparam int SLOT_SH = 3;

  localparam logic [CODE_W-1:0] C_OK    = 8'h00;
  localparam logic [CODE_W-1:0] C_PROT  = 8'h04;
  localparam logic [CODE_W-1:0] C_SEGX  = 8'h10;
  localparam logic [CODE_W-1:0] C_PAGEX = 8'h11;
  localparam logic [CODE_W-1:0] C_SPEC  = 8'h12;
  localparam logic [CODE_W-1:0] C_ATYPE = 8'h38;
  localparam logic [CODE_W-1:0] C_R1X   = 8'h39;
  localparam logic [CODE_W-1:0] C_R2X   = 8'h3A;
  localparam logic [CODE_W-1:0] C_R3X   = 8'h3B;

  // Index field of the address that selects the entry of a given level.
  function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] va, input lvl_t l);
    case (l)
      LV_R1:   return va[63:53];
      LV_R2:   return va[52:42];
      LV_R3:   return va[41:31];
      LV_SEG:  return va[30:20];
      default: return {3'b000, va[19:12]};
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] trans_code(input lvl_t l);
    case (l)
      LV_R1:   return C_R1X;
      LV_R2:   return C_R2X;
      LV_R3:   return C_R3X;
      LV_SEG:  return C_SEGX;
      default: return C_PAGEX;
    endcase
  endfunction

  function automatic lvl_t lower_level(input lvl_t l);
    case (l)
      LV_R1:   return LV_R2;
      LV_R2:   return LV_R3;
      LV_R3:   return LV_SEG;
      default: return LV_PAGE;
    endcase
  endfunction

  // 4 KiB-aligned table origin plus an 8-byte slot.
  function automatic logic [VA_W-1:0] table_slot(input logic [51:0] org, input logic [IDX_W-1:0] idx);
    return {org, 12'h000} + {50'b0, idx, 3'b000};
  endfunction

  // 2 KiB-aligned page table; the slot never carries into the origin.
  function automatic logic [VA_W-1:0] page_slot(input logic [52:0] pto, input logic [PX_W-1:0] px);
    return {pto, px, 3'b000};
  endfunction

endpackage

// File: rtl/dat_start_check.sv
module dat_start_check
  import dat_walk_pkg::*;
(
  input  logic [VA_W-1:0]   vaddr,
  input  logic [51:0]       origin,
  input  logic [1:0]        dtype,
  input  logic [1:0]        tlen,
  output lvl_t              first_lvl,
  output logic [VA_W-1:0]   first_ptr,
  output logic [CODE_W-1:0] start_code
);
  localparam int N_REGION = 3;

  logic [N_REGION:1] above_hit;
  logic [IDX_W-1:0]  start_idx;

  // One comparator per region level that may sit above the start.
  for (genvar g = 1; g <= N_REGION; g++) begin : g_above
    assign above_hit[g] = (2'(g) > dtype) && (level_index(vaddr, lvl_t'(3'(g))) != '0);
  end

  assign first_lvl = lvl_t'({1'b0, dtype});
  assign start_idx = level_index(vaddr, first_lvl);
  assign first_ptr = table_slot(origin, start_idx);

  always_comb begin
    start_code = C_OK;
    if (|above_hit)                    start_code = C_ATYPE;
    else if (start_idx[10:9] > tlen)   start_code = trans_code(first_lvl);
  end
endmodule

// File: rtl/dat_entry_eval.sv
module dat_entry_eval
  import dat_walk_pkg::*;
(
  input  lvl_t              lvl,
  input  logic [63:0]       entry,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              priv,
  input  logic              en1,
  input  logic              en2,
  output logic [CODE_W-1:0] code,
  output logic              last,
  output lvl_t              next_lvl,
  output logic [VA_W-1:0]   next_ptr,
  output logic [VA_W-1:0]   out_addr,
  output logic              prot
);
  lvl_t             nlvl;
  logic [IDX_W-1:0] nidx;
  logic [1:0]       ntop;

  assign nlvl = lower_level(lvl);
  assign nidx = level_index(vaddr, nlvl);
  assign ntop = nidx[10:9];

  always_comb begin
    code     = C_OK;
    last     = 1'b0;
    next_lvl = LV_PAGE;
    next_ptr = '0;
    out_addr = '0;
    prot     = 1'b0;
    case (lvl)
      LV_R1, LV_R2, LV_R3: begin
        if (entry[5])                          code = trans_code(lvl);
        else if (entry[3:2] != lvl[1:0])       code = C_SPEC;
        else if (lvl == LV_R3 && entry[10] && en1 && en2) begin
          last     = 1'b1;
          out_addr = {entry[63:31], vaddr[30:0]};
          prot     = entry[9];
        end
        else if (ntop < entry[7:6] || ntop > entry[1:0]) code = trans_code(nlvl);
        else begin
          next_lvl = nlvl;
          next_ptr = table_slot(entry[63:12], nidx);
          prot     = en1 & entry[9];
        end
      end
      LV_SEG: begin
        if (entry[5])                          code = C_SEGX;
        else if (entry[3:2] != 2'b00)          code = C_SPEC;
        else if (entry[4] && priv)             code = C_SPEC;
        else if (entry[10] && en1) begin
          last     = 1'b1;
          out_addr = {entry[63:20], vaddr[19:0]};
          prot     = entry[9];
        end
        else begin
          next_lvl = LV_PAGE;
          next_ptr = page_slot(entry[63:11], vaddr[19:12]);
          prot     = entry[9];
        end
      end
      default: begin
        if (entry[10])                         code = C_PAGEX;
        else if (entry[11])                    code = C_SPEC;
        else if (entry[8] && !en1)             code = C_SPEC;
        else begin
          last     = 1'b1;
          out_addr = {entry[63:12], vaddr[11:0]};
          prot     = entry[9];
        end
      end
    endcase
  end
endmodule

// File: rtl/dat_walker.sv
module dat_walker
  import dat_walk_pkg::*;
#(
  parameter logic [7:0] BUS_FAULT_CODE = 8'hF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_busy,
  input  logic [63:0] req_vaddr,
  input  logic [63:0] req_ctl,
  input  logic        req_large_en1,
  input  logic        req_large_en2,
  input  logic        req_write,
  output logic        mem_rd_valid,
  output logic [63:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        res_valid,
  output logic [63:0] res_addr,
  output logic [7:0]  res_code
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t               state;
  lvl_t              lvl_q;
  logic [VA_W-1:0]   ptr_q, va_q;
  logic              priv_q, en1_q, en2_q, wr_q, prot_q;

  lvl_t              st_lvl;
  logic [VA_W-1:0]   st_ptr;
  logic [CODE_W-1:0] st_code;

  logic [CODE_W-1:0] ev_code;
  logic              ev_last, ev_prot;
  lvl_t              ev_nlvl;
  logic [VA_W-1:0]   ev_nptr, ev_addr;

  // Named events for the assertions.
  logic accept, real_mode, rsp_take, rsp_fault, prot_hit;
  logic unused_ctl;

  assign unused_ctl = ^{req_ctl[11:9], req_ctl[7:6], req_ctl[4]};
  assign accept     = req_valid && (state == S_IDLE);
  assign real_mode  = req_ctl[5];
  assign rsp_take   = (state == S_WAIT) && mem_rsp_valid;
  assign rsp_fault  = rsp_take && mem_rsp_err;
  assign prot_hit   = wr_q && (prot_q || ev_prot);

  dat_start_check u_start (
    .vaddr     (req_vaddr),
    .origin    (req_ctl[63:12]),
    .dtype     (req_ctl[3:2]),
    .tlen      (req_ctl[1:0]),
    .first_lvl (st_lvl),
    .first_ptr (st_ptr),
    .start_code(st_code)
  );

  dat_entry_eval u_eval (
    .lvl     (lvl_q),
    .entry   (mem_rsp_data),
    .vaddr   (va_q),
    .priv    (priv_q),
    .en1     (en1_q),
    .en2     (en2_q),
    .code    (ev_code),
    .last    (ev_last),
    .next_lvl(ev_nlvl),
    .next_ptr(ev_nptr),
    .out_addr(ev_addr),
    .prot    (ev_prot)
  );

  assign req_busy     = (state != S_IDLE);
  assign mem_rd_valid = (state == S_REQ);
  assign mem_rd_addr  = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      lvl_q     <= LV_SEG;
      ptr_q     <= '0;
      va_q      <= '0;
      priv_q    <= 1'b0;
      en1_q     <= 1'b0;
      en2_q     <= 1'b0;
      wr_q      <= 1'b0;
      prot_q    <= 1'b0;
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_code  <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            va_q   <= req_vaddr;
            priv_q <= req_ctl[8];
            en1_q  <= req_large_en1;
            en2_q  <= req_large_en2;
            wr_q   <= req_write;
            prot_q <= 1'b0;
            if (real_mode) begin
              res_valid <= 1'b1;
              res_addr  <= req_vaddr;
              res_code  <= C_OK;
            end else if (st_code != C_OK) begin
              res_valid <= 1'b1;
              res_addr  <= '0;
              res_code  <= st_code;
            end else begin
              lvl_q <= st_lvl;
              ptr_q <= st_ptr;
              state <= S_REQ;
            end
          end
        end
        S_REQ: state <= S_WAIT;
        default: begin
          if (rsp_take) begin
            if (mem_rsp_err || ev_code != C_OK || ev_last) begin
              state     <= S_IDLE;
              res_valid <= 1'b1;
              res_addr  <= '0;
              if (mem_rsp_err)          res_code <= BUS_FAULT_CODE;
              else if (ev_code != C_OK) res_code <= ev_code;
              else if (prot_hit)        res_code <= C_PROT;
              else begin
                res_code <= C_OK;
                res_addr <= ev_addr;
              end
            end else begin
              prot_q <= prot_q | ev_prot;
              lvl_q  <= ev_nlvl;
              ptr_q  <= ev_nptr;
              state  <= S_REQ;
            end
          end
        end
      endcase
    end
  end

  // R1
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[2:0] == 3'b000));

  // R12
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  // R2
  real_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && real_mode) |=> (res_valid && res_code == C_OK && res_addr == $past(req_vaddr) && !req_busy));

  // R3
  asce_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !real_mode && st_code == C_ATYPE) |=> (res_valid && res_code == C_ATYPE && !mem_rd_valid));

  // R11
  bus_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |=> (res_valid && res_code == BUS_FAULT_CODE && !req_busy));

  // R10
  prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !mem_rsp_err && ev_code == C_OK && ev_last && prot_hit) |=> (res_valid && res_code == C_PROT));
endmodule

// File: tb/dat_walker_tb.sv
module dat_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_busy;
  logic [63:0] req_vaddr = '0;
  logic [63:0] req_ctl = '0;
  logic        req_large_en1 = 1'b0;
  logic        req_large_en2 = 1'b0;
  logic        req_write = 1'b0;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        res_valid;
  logic [63:0] res_addr;
  logic [7:0]  res_code;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int cycles = 0;
  logic        pend = 1'b0;
  logic [63:0] pend_addr = '0;
  logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
  logic [63:0] mem [logic [63:0]];

  always #4 clk = ~clk;  // 125 MHz

  dat_walker u_dut (.*);

  // Memory model: response two falling edges after the read request.
  function automatic logic [63:0] peek(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid <= pend;
    mem_rsp_data  <= peek(pend_addr);
    mem_rsp_err   <= pend && (pend_addr == err_addr);
    pend          <= mem_rd_valid;
    pend_addr     <= mem_rd_addr;
    if (mem_rd_valid) rd_count = rd_count + 1;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Encoders for control word and entries.
  function automatic logic [63:0] mk_ctl(input logic [63:0] org, input logic priv, input logic rl,
                                         input logic [1:0] dt, input logic [1:0] tl);
    return {org[63:12], 3'b000, priv, 2'b00, rl, 1'b0, dt, tl};
  endfunction
  function automatic logic [63:0] mk_reg(input logic [63:0] org, input logic p, input logic [1:0] tf,
                                         input logic inv, input logic [1:0] tt, input logic [1:0] tl);
    return {org[63:12], 2'b00, p, 1'b0, tf, inv, 1'b0, tt, tl};
  endfunction
  function automatic logic [63:0] mk_r3frame(input logic [63:0] fr, input logic p);
    return {fr[63:31], 20'h0, 1'b1, p, 3'b000, 1'b0, 1'b0, 2'b01, 2'b00};
  endfunction
  function automatic logic [63:0] mk_seg(input logic [63:0] org, input logic fc, input logic p,
                                         input logic inv, input logic cs, input logic [1:0] tt);
    return {org[63:11], fc, p, 3'b000, inv, cs, tt, 2'b00};
  endfunction
  function automatic logic [63:0] mk_pte(input logic [63:0] fr, input logic z, input logic inv,
                                         input logic p, input logic co);
    return {fr[63:12], z, inv, p, co, 8'h00};
  endfunction

  localparam logic [63:0] T_R1 = 64'h1_0000, T_R2 = 64'h2_0000, T_R3 = 64'h3_0000;
  localparam logic [63:0] T_SG = 64'h4_0000, T_PT = 64'h5_0000, FRAME = 64'h1_2345_6000;
  localparam logic [10:0] I_R1 = 11'h005, I_R2 = 11'h203, I_R3 = 11'h401, I_SG = 11'h0C2;
  localparam logic [7:0]  I_PX = 8'h37;
  localparam logic [11:0] I_BX = 12'hABC;
  localparam logic [63:0] VA_FULL = {I_R1, I_R2, I_R3, I_SG, I_PX, I_BX};
  localparam logic [63:0] VA_SEG  = {33'h0, I_SG, I_PX, I_BX};
  localparam logic [63:0] A_R1 = T_R1 + 64'(I_R1) * 8, A_R2 = T_R2 + 64'(I_R2) * 8;
  localparam logic [63:0] A_R3 = T_R3 + 64'(I_R3) * 8, A_SG = T_SG + 64'(I_SG) * 8;
  localparam logic [63:0] A_PT = T_PT + 64'(I_PX) * 8;
  localparam logic [63:0] PAGE_RES = FRAME + 64'(I_BX);

  task automatic build_std();
    mem.delete();
    err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
    mem[A_R1] = mk_reg(T_R2, 1'b0, 2'd0, 1'b0, 2'd3, 2'd3);
    mem[A_R2] = mk_reg(T_R3, 1'b0, 2'd0, 1'b0, 2'd2, 2'd3);
    mem[A_R3] = mk_reg(T_SG, 1'b0, 2'd0, 1'b0, 2'd1, 2'd3);
    mem[A_SG] = mk_seg(T_PT, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    mem[A_PT] = mk_pte(FRAME, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic walk(input logic [63:0] va, input logic [63:0] ctl, input logic e1, input logic e2,
                      input logic wr, output logic [63:0] addr, output logic [7:0] code, output int reads);
    int start;
    bit seen;
    @(negedge clk);
    start = rd_count;
    req_vaddr = va; req_ctl = ctl; req_large_en1 = e1; req_large_en2 = e2; req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      if (res_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    if (!seen) begin
      checks = checks + 1; errors = errors + 1;
      $display("FAIL R12: actual no result, expected one res_valid pulse");
    end
    addr = res_addr; code = res_code; reads = rd_count - start;
  endtask

  logic [63:0] CTL_R1, CTL_SG;
  logic [63:0] a; logic [7:0] c; int n;

  task automatic t_reset();
    chk("R12 reset busy", 64'(req_busy), 64'd0);
    chk("R12 reset res_valid", 64'(res_valid), 64'd0);
    chk("R12 reset rd_valid", 64'(mem_rd_valid), 64'd0);
  endtask

  task automatic t_full_walks();
    build_std();
    walk(VA_FULL, CTL_R1, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R1 five-level addr", a, PAGE_RES); chk("R1 five-level code", 64'(c), 64'h0);
    chk("R1 five-level reads", 64'(n), 64'd5);
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R1 segment-start addr", a, PAGE_RES); chk("R1 segment-start reads", 64'(n), 64'd2);
  endtask

  task automatic t_real();
    walk(64'hDEAD_BEEF_0000_1234, mk_ctl(T_R1, 1'b0, 1'b1, 2'd3, 2'd0), 1'b0, 1'b0, 1'b1, a, c, n);
    chk("R2 real addr", a, 64'hDEAD_BEEF_0000_1234); chk("R2 real code", 64'(c), 64'h0);
    chk("R2 real reads", 64'(n), 64'd0);
  endtask

  task automatic t_start_faults();
    walk(VA_SEG | (64'd1 << 31), CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R3 asce-type code", 64'(c), 64'h38); chk("R3 asce-type reads", 64'(n), 64'd0);
    walk({11'h600, 53'h0}, mk_ctl(T_R1, 1'b0, 1'b0, 2'd3, 2'd0), 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R4 region-first length code", 64'(c), 64'h39); chk("R4 length reads", 64'(n), 64'd0);
    walk({33'h0, 11'h2C2, 20'h0}, mk_ctl(T_SG, 1'b0, 1'b0, 2'd0, 2'd0), 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R4 segment length code", 64'(c), 64'h10);
  endtask

  task automatic t_entry_faults();
    build_std();
    mem[A_R2] = mk_reg(T_R3, 1'b0, 2'd0, 1'b1, 2'd2, 2'd3);
    walk(VA_FULL, CTL_R1, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R5 invalid region-second", 64'(c), 64'h3A);
    build_std();
    mem[A_R3] = mk_reg(T_SG, 1'b0, 2'd0, 1'b0, 2'd2, 2'd3);
    walk(VA_FULL, CTL_R1, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R5 table-type mismatch", 64'(c), 64'h12);
    build_std();
    mem[A_SG] = mk_seg(T_PT, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R5 invalid segment", 64'(c), 64'h10);
  endtask

  task automatic t_windows();
    build_std();
    mem[A_R1] = mk_reg(T_R2, 1'b0, 2'd2, 1'b0, 2'd3, 2'd3);
    walk(VA_FULL, CTL_R1, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R6 offset window", 64'(c), 64'h3A);
    build_std();
    mem[A_R2] = mk_reg(T_R3, 1'b0, 2'd0, 1'b0, 2'd2, 2'd1);
    walk(VA_FULL, CTL_R1, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R6 length window", 64'(c), 64'h3B);
  endtask

  task automatic t_frames();
    build_std();
    mem[A_R3] = mk_r3frame(64'h3_8000_0000, 1'b0);
    walk(VA_FULL, CTL_R1, 1'b1, 1'b1, 1'b0, a, c, n);
    chk("R7 region frame addr", a, 64'h3_8000_0000 | (VA_FULL & 64'h7FFF_FFFF));
    chk("R7 region frame reads", 64'(n), 64'd3);
    walk(VA_FULL, CTL_R1, 1'b1, 1'b0, 1'b0, a, c, n);
    chk("R7 frame ignored without enable", a, 64'(I_BX));
    build_std();
    mem[A_SG] = mk_seg(64'h7_0010_0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    walk(VA_SEG, CTL_SG, 1'b1, 1'b0, 1'b0, a, c, n);
    chk("R8 segment frame addr", a, 64'h7_0010_0000 | (VA_SEG & 64'hF_FFFF));
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R8 segment frame ignored", a, 64'(I_BX));
    build_std();
    mem[A_SG] = mk_seg(T_PT, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
    walk(VA_SEG, mk_ctl(T_SG, 1'b1, 1'b0, 2'd0, 2'd3), 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R8 common with private", 64'(c), 64'h12);
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R8 common without private", a, PAGE_RES);
  endtask

  task automatic t_page();
    build_std();
    mem[A_PT] = mk_pte(FRAME, 1'b0, 1'b1, 1'b0, 1'b0);
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R9 page invalid", 64'(c), 64'h11);
    mem[A_PT] = mk_pte(FRAME, 1'b1, 1'b0, 1'b0, 1'b0);
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R9 page zero bit", 64'(c), 64'h12);
    mem[A_PT] = mk_pte(FRAME, 1'b0, 1'b0, 1'b0, 1'b1);
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R9 override without enable", 64'(c), 64'h12);
    walk(VA_SEG, CTL_SG, 1'b1, 1'b0, 1'b0, a, c, n);
    chk("R9 override with enable", a, PAGE_RES);
  endtask

  task automatic t_prot();
    build_std();
    mem[A_PT] = mk_pte(FRAME, 1'b0, 1'b0, 1'b1, 1'b0);
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b1, a, c, n);
    chk("R10 page prot write", 64'(c), 64'h04);
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R10 page prot read", a, PAGE_RES);
    build_std();
    mem[A_R1] = mk_reg(T_R2, 1'b1, 2'd0, 1'b0, 2'd3, 2'd3);
    walk(VA_FULL, CTL_R1, 1'b0, 1'b0, 1'b1, a, c, n);
    chk("R10 region prot ignored", a, PAGE_RES);
    walk(VA_FULL, CTL_R1, 1'b1, 1'b0, 1'b1, a, c, n);
    chk("R10 region prot counted", 64'(c), 64'h04);
  endtask

  task automatic t_bus();
    build_std();
    err_addr = A_SG;
    walk(VA_SEG, CTL_SG, 1'b0, 1'b0, 1'b0, a, c, n);
    chk("R11 bus error code", 64'(c), 64'hF0); chk("R11 bus error reads", 64'(n), 64'd1);
    err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
  endtask

  task automatic t_busy();
    int pulses = 0;
    logic [63:0] got = '0;
    build_std();
    @(negedge clk);
    req_vaddr = VA_FULL; req_ctl = CTL_R1; req_large_en1 = 0; req_large_en2 = 0; req_write = 0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy after accept", 64'(req_busy), 64'd1);
    req_vaddr = 64'h55; req_ctl = mk_ctl(T_R1, 1'b0, 1'b1, 2'd3, 2'd0); req_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (res_valid) begin pulses++; got = res_addr; end
      @(negedge clk);
    end
    chk("R12 single pulse", 64'(pulses), 64'd1);
    chk("R12 request while busy ignored", got, PAGE_RES);
  endtask

  initial begin
    CTL_R1 = mk_ctl(T_R1, 1'b0, 1'b0, 2'd3, 2'd3);
    CTL_SG = mk_ctl(T_SG, 1'b0, 1'b0, 2'd0, 2'd3);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_full_walks();
    t_real();
    t_start_faults();
    t_entry_faults();
    t_windows();
    t_frames();
    t_page();
    t_prot();
    t_bus();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule